// File: doc/BRIEF.md
# Variable-Width Pixel Item Serializer

This block turns a stream of 32-bit video double-words for one display channel into a stream of pixel items that are 1, 2, 4 or 8 bits wide. Words arrive over a valid/ready handshake. They pass through a two-entry staging path: a front holding register, then a back holding register. A 32-bit shift register takes the next word from the back register. On the way into the front register each word is rearranged by a size-dependent bit transpose. After that, shifting the register left by one place per item, and reading fixed taps spaced 32/N apart, gives the items in order. The first item comes from the most significant end of the original word.

Items advance on an item tick. The tick is the pixel-enable input divided by 1, 2 or 4, chosen by a 2-bit resolution code. Every item leaves the block as an 8-bit value, with the item in the top N bits and zeros below. If the channel is off, or the size code is illegal, the block emits zeros. It reports a starved shift register and an illegal size code through two flags that stay set until reset.

The shift-register controller is a three-state machine:
- SH_OFF: the channel is disabled. It moves to SH_EMPTY when the channel is enabled, or moves to SH_RUN if a tick and a buffered word are both present.
- SH_EMPTY: the channel is on but no word is loaded. On a tick it moves to SH_RUN if the back register holds a word. Otherwise it stays and raises an underrun.
- SH_RUN: a word is being shifted out. On a tick it shifts. After the last item of the word it reloads and stays, or moves to SH_EMPTY with an underrun if no word is waiting.
- Disabling the channel returns the machine to SH_OFF from any state.

Top module: `pixel_item_serializer`

## Requirements
- R1: The size field is one-hot: bit 0 selects 1-bit, bit 1 selects 2-bit, bit 2 selects 4-bit and bit 3 selects 8-bit items. Within each input word, item k is taken from word bits [31-k*N : 32-(k+1)*N], so the first item comes from the most significant end.
- R2: The item output is 8 bits wide. An N-bit item sits in bits [7:8-N], and bits [7-N:0] are zero.
- R3: While the channel enable is low, the item is 0 and the item strobe is low.
- R4: With pixel enable held high, items advance every cycle for resolution code 3, every 2 cycles for code 2, and every 4 cycles for codes 0 and 1.
- R5: Each word yields exactly 32/N items. The next word's first item follows on the very next tick, with no gap, while words keep arriving.
- R6: in_ready is low while the front register is full. Two words can be held before the channel starts, and a stalled word is not lost or overwritten.
- R7: A tick that needs a new word when none is buffered gives item 0 with the strobe low, and sets the underrun flag. The flag stays set until reset.
- R8: A size field with other than exactly one bit set is treated as channel off, giving item 0 and the strobe low. It also sets the size-error flag, which stays set until reset.
- R9: After reset, in_ready is 1, the item is 0, the strobe is 0, and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_en | input | 1 | One-cycle pulse per pixel clock |
| chan_on | input | 1 | Channel enable |
| size_sel | input | 4 | One-hot item size (1/2/4/8 bits) |
| res_code | input | 2 | Resolution: 3 full, 2 half, 0/1 quarter |
| in_valid | input | 1 | Input word valid |
| in_data | input | 32 | Input double-word, as read from memory |
| in_ready | output | 1 | Front register can accept a word |
| item | output | 8 | Current pixel item, left-aligned |
| item_stb | output | 1 | High for the cycle a new item appears |
| underrun | output | 1 | Sticky: shift register starved |
| size_err | output | 1 | Sticky: illegal size code seen while enabled |

## Verification
A wrong transpose or a wrong tap shows up at the port on the very first strobed item of a word, as a value that does not match the expected slice of the unpermuted word. An off-by-one in the item counter shows up at the word boundary: the item after the 32/N-th one either repeats a bit slice or skips one. An error in the divider or the state machine shows up as wrong strobe spacing within one item period. A lost or overwritten buffered word shows up as a whole word of wrong items in place of the word that stalled. An error in the reload or the underrun logic appears within one tick after the last buffered item.

// File: rtl/pis_pkg.sv
package pis_pkg;
    localparam int WORD_W  = 32;
    localparam int ITEM_W  = 8;
    localparam int NSIZES  = $clog2(ITEM_W) + 1;
    localparam int CNT_W   = $clog2(WORD_W);

    typedef enum logic [1:0] {
        SH_OFF   = 2'd0,
        SH_EMPTY = 2'd1,
        SH_RUN   = 2'd2
    } sh_state_t;

    // exactly one bit set
    function automatic logic size_legal(input logic [NSIZES-1:0] s);
        return (s != '0) && ((s & (s - 1'b1)) == '0);
    endfunction
endpackage

// File: rtl/pis_rate_div.sv
module pis_rate_div
    import pis_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       chan_ok,
    input  logic       pix_en,
    input  logic [1:0] res_code,
    output logic       tick
);
    logic [1:0] div_cnt;
    logic [1:0] div_max;

    always_comb begin
        unique case (res_code)
            2'b11:   div_max = 2'd0;
            2'b10:   div_max = 2'd1;
            default: div_max = 2'd3;
        endcase
    end

    assign tick = chan_ok && pix_en && (div_cnt == div_max);

    always_ff @(posedge clk) begin
        if (!rst_n || !chan_ok) begin
            div_cnt <= 2'd0;
        end else if (pix_en) begin
            div_cnt <= (div_cnt == div_max) ? 2'd0 : div_cnt + 2'd1;
        end
    end

    // R4: full resolution passes every pixel enable straight through
    a_r4_full_rate: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_ok && res_code == 2'b11 && pix_en) |-> tick);
endmodule

// File: rtl/pis_permute.sv
module pis_permute
    import pis_pkg::*;
(
    input  logic [NSIZES-1:0] size_sel,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout
);
    // Transpose so tap j at step m yields word bit (m*n + j) from the top.
    always_comb begin
        int n;
        int k;
        n = 1;
        for (int s = 0; s < NSIZES; s++) begin
            if (size_sel[s]) n = 1 << s;
        end
        k = WORD_W / n;
        dout = '0;
        for (int j = 0; j < ITEM_W; j++) begin
            for (int m = 0; m < WORD_W; m++) begin
                if (j < n && m < k) begin
                    dout[WORD_W-1-(j*k+m)] = din[WORD_W-1-(m*n+j)];
                end
            end
        end
    end
endmodule

// File: rtl/pis_buffer.sv
module pis_buffer
    import pis_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    output logic              in_ready,
    input  logic              load,
    output logic              back_valid,
    output logic [WORD_W-1:0] back_word
);
    logic              front_valid;
    logic [WORD_W-1:0] front_word;
    logic              accept;
    logic              advance;

    assign in_ready = !front_valid;
    assign accept   = in_valid && !front_valid;
    assign advance  = front_valid && (!back_valid || load);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            front_valid <= 1'b0;
            back_valid  <= 1'b0;
            front_word  <= '0;
            back_word   <= '0;
        end else begin
            if (accept) begin
                front_valid <= 1'b1;
                front_word  <= in_word;
            end else if (advance) begin
                front_valid <= 1'b0;
            end
            if (advance) begin
                back_valid <= 1'b1;
                back_word  <= front_word;
            end else if (load) begin
                back_valid <= 1'b0;
            end
        end
    end

    // R6: a held front word is never dropped or overwritten
    a_r6_front_held: assert property (@(posedge clk) disable iff (!rst_n)
        (front_valid && !advance) |=> (front_valid && $stable(front_word)));
    // R6: the shift register never loads from an empty back register
    a_r6_load_has_word: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> back_valid);
endmodule

// File: rtl/pis_shifter.sv
module pis_shifter
    import pis_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chan_ok,
    input  logic              tick,
    input  logic [NSIZES-1:0] size_sel,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word,
    output logic              load,
    output logic              starve,
    output logic [ITEM_W-1:0] item,
    output logic              item_stb
);
    sh_state_t         state, state_nxt;
    logic [WORD_W-1:0] sr;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  last_idx;
    logic              shift;
    logic              stb_q;
    logic [ITEM_W-1:0] taps;
    logic [ITEM_W-1:0] tap_by_size [NSIZES];

    for (genvar s = 0; s < NSIZES; s++) begin : g_size
        localparam int N = 1 << s;
        localparam int K = WORD_W / N;
        for (genvar j = 0; j < ITEM_W; j++) begin : g_bit
            if (j < N) begin : g_tap
                assign tap_by_size[s][ITEM_W-1-j] = sr[WORD_W-1-j*K];
            end else begin : g_zero
                assign tap_by_size[s][ITEM_W-1-j] = 1'b0;
            end
        end
    end

    always_comb begin
        taps     = '0;
        last_idx = '1;
        for (int s = 0; s < NSIZES; s++) begin
            if (size_sel[s]) begin
                taps     = tap_by_size[s];
                last_idx = CNT_W'((WORD_W >> s) - 1);
            end
        end
    end

    // next-state process
    always_comb begin
        state_nxt = state;
        load      = 1'b0;
        shift     = 1'b0;
        starve    = 1'b0;
        unique case (state)
            SH_OFF, SH_EMPTY: begin
                if (!chan_ok) begin
                    state_nxt = SH_OFF;
                end else if (tick) begin
                    if (word_valid) begin
                        load      = 1'b1;
                        state_nxt = SH_RUN;
                    end else begin
                        starve    = 1'b1;
                        state_nxt = SH_EMPTY;
                    end
                end else begin
                    state_nxt = SH_EMPTY;
                end
            end
            SH_RUN: begin
                if (!chan_ok) begin
                    state_nxt = SH_OFF;
                end else if (tick) begin
                    if (cnt != last_idx) begin
                        shift = 1'b1;
                    end else if (word_valid) begin
                        load = 1'b1;
                    end else begin
                        starve    = 1'b1;
                        state_nxt = SH_EMPTY;
                    end
                end
            end
            default: state_nxt = SH_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SH_OFF;
            sr    <= '0;
            cnt   <= '0;
            stb_q <= 1'b0;
        end else begin
            state <= state_nxt;
            stb_q <= load || shift;
            if (load) begin
                sr  <= word;
                cnt <= '0;
            end else if (shift) begin
                sr  <= sr << 1;
                cnt <= cnt + 1'b1;
            end
        end
    end

    // output process
    always_comb begin
        if (chan_ok && state == SH_RUN) begin
            item     = taps;
            item_stb = stb_q;
        end else begin
            item     = '0;
            item_stb = 1'b0;
        end
    end

    // R7: a starved tick leaves no item behind it
    a_r7_starve_blank: assert property (@(posedge clk) disable iff (!rst_n)
        starve |=> (item == '0 && !item_stb));
    // R5: a shift only happens inside a loaded word
    a_r5_shift_in_word: assert property (@(posedge clk) disable iff (!rst_n)
        shift |-> (state == SH_RUN));
endmodule

// File: rtl/pixel_item_serializer.sv
module pixel_item_serializer
    import pis_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_en,
    input  logic              chan_on,
    input  logic [NSIZES-1:0] size_sel,
    input  logic [1:0]        res_code,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    output logic              in_ready,
    output logic [ITEM_W-1:0] item,
    output logic              item_stb,
    output logic              underrun,
    output logic              size_err
);
    logic              legal;
    logic              chan_ok;
    logic              tick;
    logic              load;
    logic              starve;
    logic              back_valid;
    logic [WORD_W-1:0] back_word;
    logic [WORD_W-1:0] perm_word;

    assign legal   = size_legal(size_sel);
    assign chan_ok = chan_on && legal;

    pis_rate_div u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .chan_ok  (chan_ok),
        .pix_en   (pix_en),
        .res_code (res_code),
        .tick     (tick)
    );

    pis_permute u_perm (
        .size_sel (size_sel),
        .din      (in_data),
        .dout     (perm_word)
    );

    pis_buffer u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_word    (perm_word),
        .in_ready   (in_ready),
        .load       (load),
        .back_valid (back_valid),
        .back_word  (back_word)
    );

    pis_shifter u_sh (
        .clk        (clk),
        .rst_n      (rst_n),
        .chan_ok    (chan_ok),
        .tick       (tick),
        .size_sel   (size_sel),
        .word_valid (back_valid),
        .word       (back_word),
        .load       (load),
        .starve     (starve),
        .item       (item),
        .item_stb   (item_stb)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            underrun <= 1'b0;
            size_err <= 1'b0;
        end else begin
            if (starve) underrun <= 1'b1;
            if (chan_on && !legal) size_err <= 1'b1;
        end
    end

    // R2: unused low item bits stay zero
    a_r2_one_bit_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (size_sel == 4'b0001) |-> (item[6:0] == 7'd0));
    a_r2_four_bit_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (size_sel == 4'b0100) |-> (item[3:0] == 4'd0));
    // R3: a disabled channel is silent
    a_r3_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_on |-> (item == '0 && !item_stb));
    // R8: an illegal size while enabled flags the error and blanks
    a_r8_illegal_size: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_on && !legal) |=> size_err);
endmodule

// File: tb/pixel_item_serializer_bench.sv
module pixel_item_serializer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_en = 1'b1;
    logic        chan_on = 1'b0;
    logic [3:0]  size_sel = 4'b1000;
    logic [1:0]  res_code = 2'b11;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_ready;
    logic [7:0]  item;
    logic        item_stb;
    logic        underrun;
    logic        size_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] words [4];
    logic [7:0]  exp_items [128];

    always #10 clk = ~clk;

    pixel_item_serializer u_pixel_item_serializer (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .chan_on(chan_on),
        .size_sel(size_sel), .res_code(res_code), .in_valid(in_valid),
        .in_data(in_data), .in_ready(in_ready), .item(item),
        .item_stb(item_stb), .underrun(underrun), .size_err(size_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        chan_on = 1'b0; in_valid = 1'b0; rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic push_word(input logic [31:0] w);
        in_valid = 1'b1;
        in_data  = w;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    function automatic int bits_of(input logic [3:0] sz);
        case (sz)
            4'b0001: return 1;
            4'b0010: return 2;
            4'b0100: return 4;
            default: return 8;
        endcase
    endfunction

    task automatic test_reset();
        do_reset();
        check(in_ready == 1'b1, "R9 in_ready", int'(in_ready), 1);
        check(item == 8'd0, "R9 item", int'(item), 0);
        check(item_stb == 1'b0, "R9 strobe", int'(item_stb), 0);
        check(underrun == 1'b0 && size_err == 1'b0, "R9 flags",
              int'({underrun, size_err}), 0);
    endtask

    // R1 R2 R4 R5 R7: stream nw words, check order, spacing, then starvation
    task automatic test_stream(input logic [3:0] sz, input logic [1:0] res,
                               input int nw, input int gap, input string tag);
        int n;
        int per_word;
        int total;
        int idx;
        int last_cyc;
        int cyc;
        n = bits_of(sz);
        per_word = 32 / n;
        total = nw * per_word;
        for (int w = 0; w < nw; w++) begin
            words[w] = 32'h9E37_79B9 ^ (32'h2545_F491 * (w + 1)) ^ {24'd0, tag.len()[7:0]};
            for (int k = 0; k < per_word; k++) begin
                logic [31:0] v;
                v = (words[w] >> (32 - n * (k + 1))) & ((32'd1 << n) - 1);
                exp_items[w * per_word + k] = 8'(v << (8 - n));
            end
        end
        do_reset();
        size_sel = sz;
        res_code = res;
        push_word(words[0]);
        push_word(words[1]);
        idx = 0; last_cyc = 0; cyc = 0;
        fork
            begin
                for (int w = 2; w < nw; w++) push_word(words[w]);
            end
            begin
                chan_on = 1'b1;
                while (idx < total && cyc < 3000) begin
                    @(negedge clk);
                    cyc++;
                    if (item_stb) begin
                        check(item == exp_items[idx], {tag, " R1 R2 item value"},
                              int'(item), int'(exp_items[idx]));
                        if (idx > 0)
                            check(cyc - last_cyc == gap, {tag, " R4 R5 item spacing"},
                                  cyc - last_cyc, gap);
                        last_cyc = cyc;
                        idx++;
                    end
                end
            end
        join
        check(idx == total, {tag, " R5 item count"}, idx, total);
        check(underrun == 1'b0, {tag, " R7 no early underrun"}, int'(underrun), 0);
        repeat (2 * gap + 2) @(negedge clk);
        check(underrun == 1'b1, {tag, " R7 underrun set"}, int'(underrun), 1);
        check(item == 8'd0 && !item_stb, {tag, " R7 blank when starved"},
              int'({item_stb, item}), 0);
        repeat (8) @(negedge clk);
        check(underrun == 1'b1, {tag, " R7 underrun sticky"}, int'(underrun), 1);
        chan_on = 1'b0;
    endtask

    // R6: stall with two words buffered, first word survives
    task automatic test_stall();
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] c;
        a = 32'hF0E1_D2C3; b = 32'h0123_4567; c = 32'h89AB_CDEF;
        do_reset();
        size_sel = 4'b1000;
        res_code = 2'b11;
        push_word(a);
        push_word(b);
        in_valid = 1'b1;
        in_data  = c;
        repeat (5) @(negedge clk);
        check(in_ready == 1'b0, "R6 in_ready low when full", int'(in_ready), 0);
        in_valid = 1'b0;
        chan_on = 1'b1;
        while (!item_stb) @(negedge clk);
        check(item == a[31:24], "R6 first word intact", int'(item), int'(a[31:24]));
        @(negedge clk);
        check(item == a[23:16], "R6 second item of first word", int'(item), int'(a[23:16]));
        repeat (3) @(negedge clk);
        check(item == b[31:24], "R6 second word follows", int'(item), int'(b[31:24]));
        chan_on = 1'b0;
    endtask

    // R3: disabling mid-stream blanks the output at once
    task automatic test_off();
        do_reset();
        size_sel = 4'b0001;
        res_code = 2'b11;
        push_word(32'hFFFF_FFFF);
        push_word(32'hFFFF_FFFF);
        chan_on = 1'b1;
        repeat (6) @(negedge clk);
        check(item == 8'h80, "R3 running item before off", int'(item), 8'h80);
        chan_on = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check(item == 8'd0 && !item_stb, "R3 off gives zero", int'({item_stb, item}), 0);
        end
    endtask

    // R8: two bits set in the size field
    task automatic test_illegal();
        do_reset();
        size_sel = 4'b0011;
        res_code = 2'b11;
        push_word(32'hFFFF_FFFF);
        push_word(32'hFFFF_FFFF);
        chan_on = 1'b1;
        repeat (6) begin
            @(negedge clk);
            check(item == 8'd0 && !item_stb, "R8 illegal size blanks", int'({item_stb, item}), 0);
        end
        check(size_err == 1'b1, "R8 size_err set", int'(size_err), 1);
        check(underrun == 1'b0, "R8 no underrun while blanked", int'(underrun), 0);
        chan_on = 1'b0;
        size_sel = 4'b1000;
        repeat (3) @(negedge clk);
        check(size_err == 1'b1, "R8 size_err sticky", int'(size_err), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        test_reset();
        test_stream(4'b1000, 2'b11, 3, 1, "r1_size8_full");
        test_stream(4'b0100, 2'b10, 2, 2, "r4_size4_half");
        test_stream(4'b0010, 2'b00, 2, 4, "r4_size2_quarter");
        test_stream(4'b0001, 2'b11, 2, 1, "r1_size1_full");
        test_stream(4'b1000, 2'b01, 2, 4, "r4_code1_quarter");
        test_stall();
        test_off();
        test_illegal();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule